// File: doc/BRIEF.md
# Processing-Matrix Compute Cell

This block is a single cell of a grid of processing elements arranged in rows and columns. Every cycle it receives one wide control word that is shared by the whole grid. The word carries one enable bit for each row. A cell whose row bit is set picks up to two operands and runs one operation. The result goes to one of three places inside the cell.

Operands can come from five places: the column links, the row links, the memory link, either read port of a local register file, or the cell's own stored block word. The source field sets which operand is first and which is second, so subtraction and shifts can be run in either direction. Four compute units are available: a right shifter, an ALU, a multiplier that keeps the low half of the product, and a small lookup table. There are also two load-type operations. One copies an operand straight to a destination. The other writes one entry of the lookup table. The bypass register is driven out so that neighbouring cells can pick it up on their links.

Top module: `pm_cell`

## Requirements
- R1: While rst_n is low, and just after it is released, the block word, the bypass register, all 8 register-file entries and all 16 lookup-table entries read as zero.
- R2: Bit 22+ROW_IDX of the control word enables this cell (ROW_IDX defaults to 1). When that bit is 0, no storage in the cell changes on that clock edge.
- R3: Control word bit fields: [25:22] row enables, [21:19] opcode, [18:17] function, [16:14] first-operand source, [13:11] second-operand source, [10:9] destination, [8:6] address S1, [5:3] address S2, [2:0] destination address.
- R4: Source codes: 0 = column link[S1], 1 = row link[S2], 2 = memory link[S2], 3 = register file[S1] (port A), 4 = register file[S2] (port B), 5 = block word, 6 and 7 = zero. Link word k sits at bits [16k+15:16k] of its 128-bit port.
- R5: Opcode 0 (load) writes the first operand unchanged to the selected destination.
- R6: Opcode 4 shifts the first operand right by the low 4 bits of the second operand. It is a logical shift when function bit 0 is 0 and an arithmetic shift when it is 1.
- R7: Opcode 5 is the ALU, working modulo 2^16. Function 0 gives first+second, 1 gives first-second, 2 gives AND, 3 gives XOR.
- R8: Opcode 6 writes the low 16 bits of first*second.
- R9: Opcode 1 writes the first operand into lookup entry [second operand bits 3:0] and changes nothing else. Opcode 7 produces lookup entry [first operand bits 3:0] as its result.
- R10: Destination codes: 0 = block word, 1 = bypass register, 2 = register file at the destination address, 3 = nothing. Exactly one target changes per result.
- R11: Opcodes 2 and 3 change no storage.
- R12: blockWordOut always shows the block word and bypassOut always shows the bypass register. Both hold their values between writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 26 | Control word shared across the grid |
| colLinkIn | input | 128 | Eight 16-bit words from the column links |
| rowLinkIn | input | 128 | Eight 16-bit words from the row links |
| memLinkIn | input | 128 | Eight 16-bit words from the memory link |
| blockWordOut | output | 16 | Current stored block word |
| bypassOut | output | 16 | Bypass register, sent to neighbouring cells |

## Verification
The hardest part to observe is the cell's hidden storage: the register file and the lookup table have no port of their own. A write to them can only be seen on a later cycle, when a load or a lookup instruction routes that entry to the block word or the bypass register. The stimulus therefore mixes directed pairs of instructions (first a write, then a read-back, and for the lookup table a table write, then a lookup through the indexed nibble) with a long random stream. In that stream, register-file reads, lookups and gated rows keep bringing earlier writes to the outputs, where a behavioural model is compared against them on every cycle.

// File: rtl/pm_cell_pkg.sv
package pm_cell_pkg;

  localparam logic [2:0] OPC_LOAD  = 3'd0;
  localparam logic [2:0] OPC_LUTWR = 3'd1;
  localparam logic [2:0] OPC_SHR   = 3'd4;
  localparam logic [2:0] OPC_ALU   = 3'd5;
  localparam logic [2:0] OPC_MUL   = 3'd6;
  localparam logic [2:0] OPC_LUT   = 3'd7;

  localparam logic [2:0] SRC_COL  = 3'd0;
  localparam logic [2:0] SRC_ROW  = 3'd1;
  localparam logic [2:0] SRC_MEM  = 3'd2;
  localparam logic [2:0] SRC_RFA  = 3'd3;
  localparam logic [2:0] SRC_RFB  = 3'd4;
  localparam logic [2:0] SRC_BLK  = 3'd5;

  localparam logic [1:0] DST_BLOCK  = 2'd0;
  localparam logic [1:0] DST_BYPASS = 2'd1;
  localparam logic [1:0] DST_RF     = 2'd2;

  typedef enum logic [2:0] {
    UNIT_NONE, UNIT_PASS, UNIT_SHR, UNIT_ALU, UNIT_MUL, UNIT_LUT
  } unit_e;

  typedef struct packed {
    logic       wrBlock;
    logic       wrBypass;
    logic       wrRf;
    logic       wrLut;
    unit_e      unit;
    logic [1:0] func;
    logic [2:0] srcA;
    logic [2:0] srcB;
  } strobe_t;

endpackage

// File: rtl/pm_cell_ctrl.sv
module pm_cell_ctrl
  import pm_cell_pkg::*;
#(
  parameter int NUM_ROWS = 4,
  parameter int ROW_IDX  = 1,
  parameter int AW       = 3,
  localparam int INSTR_W = NUM_ROWS + 13 + 3 * AW
) (
  input  logic [INSTR_W-1:0] instr,
  output strobe_t            strb,
  output logic [AW-1:0]      addrS1,
  output logic [AW-1:0]      addrS2,
  output logic [AW-1:0]      addrD
);
  localparam int DST_LSB = 3 * AW;
  localparam int SB_LSB  = DST_LSB + 2;
  localparam int SA_LSB  = SB_LSB + 3;
  localparam int FN_LSB  = SA_LSB + 3;
  localparam int OPC_LSB = FN_LSB + 2;
  localparam int ROW_LSB = OPC_LSB + 3;

  logic [NUM_ROWS-1:0] rowEn;
  logic [2:0]          opcode;
  logic [1:0]          dest;
  logic                rowActive;
  logic                makesResult;

  assign rowEn  = instr[ROW_LSB +: NUM_ROWS];
  assign opcode = instr[OPC_LSB +: 3];
  assign dest   = instr[DST_LSB +: 2];
  assign addrD  = instr[0 +: AW];
  assign addrS2 = instr[AW +: AW];
  assign addrS1 = instr[2*AW +: AW];

  // R2: only this cell's row bit matters
  assign rowActive = |(rowEn & (NUM_ROWS'(1) << ROW_IDX));

  always_comb begin
    strb.func = instr[FN_LSB +: 2];
    strb.srcA = instr[SA_LSB +: 3];
    strb.srcB = instr[SB_LSB +: 3];
    strb.wrLut = 1'b0;
    case (opcode)
      OPC_LOAD:  strb.unit = UNIT_PASS;
      OPC_SHR:   strb.unit = UNIT_SHR;
      OPC_ALU:   strb.unit = UNIT_ALU;
      OPC_MUL:   strb.unit = UNIT_MUL;
      OPC_LUT:   strb.unit = UNIT_LUT;
      OPC_LUTWR: begin
        strb.unit  = UNIT_NONE;
        strb.wrLut = rowActive;
      end
      default:   strb.unit = UNIT_NONE;
    endcase
    makesResult   = rowActive && (strb.unit != UNIT_NONE);
    strb.wrBlock  = makesResult && (dest == DST_BLOCK);
    strb.wrBypass = makesResult && (dest == DST_BYPASS);
    strb.wrRf     = makesResult && (dest == DST_RF);
  end
endmodule

// File: rtl/pm_cell_units.sv
module pm_cell_units
  import pm_cell_pkg::*;
#(
  parameter int DW = 16,
  localparam int SH_W = $clog2(DW)
) (
  input  unit_e         unit,
  input  logic [1:0]    func,
  input  logic [DW-1:0] opA,
  input  logic [DW-1:0] opB,
  input  logic [DW-1:0] lutRd,
  output logic [DW-1:0] result
);
  logic [SH_W-1:0] shAmt;
  logic [DW-1:0]   shOut;
  logic [DW-1:0]   aluOut;
  logic [DW-1:0]   mulLow;

  assign shAmt  = opB[SH_W-1:0];
  assign shOut  = func[0] ? DW'($signed(opA) >>> shAmt) : (opA >> shAmt);
  assign mulLow = opA * opB;

  always_comb begin
    case (func)
      2'd0:    aluOut = opA + opB;
      2'd1:    aluOut = opA - opB;
      2'd2:    aluOut = opA & opB;
      default: aluOut = opA ^ opB;
    endcase
  end

  always_comb begin
    case (unit)
      UNIT_PASS: result = opA;
      UNIT_SHR:  result = shOut;
      UNIT_ALU:  result = aluOut;
      UNIT_MUL:  result = mulLow;
      UNIT_LUT:  result = lutRd;
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/pm_cell_dp.sv
module pm_cell_dp
  import pm_cell_pkg::*;
#(
  parameter int DW        = 16,
  parameter int RF_DEPTH  = 8,
  parameter int LUT_DEPTH = 16,
  localparam int AW     = $clog2(RF_DEPTH),
  localparam int LUT_AW = $clog2(LUT_DEPTH),
  localparam int LINKS  = RF_DEPTH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             strb,
  input  logic [AW-1:0]       addrS1,
  input  logic [AW-1:0]       addrS2,
  input  logic [AW-1:0]       addrD,
  input  logic [LINKS*DW-1:0] colLinkIn,
  input  logic [LINKS*DW-1:0] rowLinkIn,
  input  logic [LINKS*DW-1:0] memLinkIn,
  output logic [DW-1:0]       blockWordOut,
  output logic [DW-1:0]       bypassOut
);
  logic [DW-1:0] rf  [RF_DEPTH];
  logic [DW-1:0] lut [LUT_DEPTH];
  logic [DW-1:0] colW [LINKS];
  logic [DW-1:0] rowW [LINKS];
  logic [DW-1:0] memW [LINKS];
  logic [DW-1:0] operand [2];
  logic [DW-1:0] blockWord, bypassReg, result, lutRd;

  for (genvar k = 0; k < LINKS; k++) begin : g_links
    assign colW[k] = colLinkIn[k*DW +: DW];
    assign rowW[k] = rowLinkIn[k*DW +: DW];
    assign memW[k] = memLinkIn[k*DW +: DW];
  end

  // R4: operand selection; slot 0 is the first operand, slot 1 the second
  for (genvar g = 0; g < 2; g++) begin : g_opmux
    logic [2:0] sel;
    assign sel = (g == 0) ? strb.srcA : strb.srcB;
    always_comb begin
      case (sel)
        SRC_COL: operand[g] = colW[addrS1];
        SRC_ROW: operand[g] = rowW[addrS2];
        SRC_MEM: operand[g] = memW[addrS2];
        SRC_RFA: operand[g] = rf[addrS1];
        SRC_RFB: operand[g] = rf[addrS2];
        SRC_BLK: operand[g] = blockWord;
        default: operand[g] = '0;
      endcase
    end
  end

  assign lutRd = lut[operand[0][LUT_AW-1:0]];

  pm_cell_units #(.DW(DW)) i_units (
    .unit  (strb.unit),
    .func  (strb.func),
    .opA   (operand[0]),
    .opB   (operand[1]),
    .lutRd (lutRd),
    .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blockWord <= '0;
      bypassReg <= '0;
      for (int i = 0; i < RF_DEPTH; i++) rf[i] <= '0;
      for (int i = 0; i < LUT_DEPTH; i++) lut[i] <= '0;
    end else begin
      if (strb.wrBlock)  blockWord <= result;
      if (strb.wrBypass) bypassReg <= result;
      if (strb.wrRf)     rf[addrD] <= result;
      if (strb.wrLut)    lut[operand[1][LUT_AW-1:0]] <= operand[0];
    end
  end

  assign blockWordOut = blockWord;
  assign bypassOut    = bypassReg;

  assert_load_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrBlock && strb.unit == UNIT_PASS) |=> (blockWordOut == $past(operand[0])));

  assert_bypass_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrBypass |=> $stable(bypassOut));
endmodule

// File: rtl/pm_cell.sv
module pm_cell
  import pm_cell_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int RF_DEPTH  = 8,
  parameter int LUT_DEPTH = 16,
  parameter int NUM_ROWS  = 4,
  parameter int ROW_IDX   = 1,
  localparam int AW      = $clog2(RF_DEPTH),
  localparam int LINKS   = RF_DEPTH,
  localparam int INSTR_W = NUM_ROWS + 13 + 3 * AW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INSTR_W-1:0]      instr,
  input  logic [LINKS*DATA_W-1:0] colLinkIn,
  input  logic [LINKS*DATA_W-1:0] rowLinkIn,
  input  logic [LINKS*DATA_W-1:0] memLinkIn,
  output logic [DATA_W-1:0]       blockWordOut,
  output logic [DATA_W-1:0]       bypassOut
);
  localparam int OPC_LSB = 3 * AW + 10;
  localparam int ROW_LSB = OPC_LSB + 3;

  strobe_t       strb;
  logic [AW-1:0] addrS1, addrS2, addrD;

  pm_cell_ctrl #(.NUM_ROWS(NUM_ROWS), .ROW_IDX(ROW_IDX), .AW(AW)) i_ctrl (
    .instr (instr),
    .strb  (strb),
    .addrS1(addrS1),
    .addrS2(addrS2),
    .addrD (addrD)
  );

  pm_cell_dp #(.DW(DATA_W), .RF_DEPTH(RF_DEPTH), .LUT_DEPTH(LUT_DEPTH)) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .addrS1      (addrS1),
    .addrS2      (addrS2),
    .addrD       (addrD),
    .colLinkIn   (colLinkIn),
    .rowLinkIn   (rowLinkIn),
    .memLinkIn   (memLinkIn),
    .blockWordOut(blockWordOut),
    .bypassOut   (bypassOut)
  );

  assert_row_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr[ROW_LSB + ROW_IDX] |=> ($stable(blockWordOut) && $stable(bypassOut)));

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrBlock, strb.wrBypass, strb.wrRf, strb.wrLut}));

  assert_idle_opcode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[OPC_LSB +: 3] == 3'd2 || instr[OPC_LSB +: 3] == 3'd3)
      |=> ($stable(blockWordOut) && $stable(bypassOut)));

  assert_block_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrBlock |=> $stable(blockWordOut));
endmodule

// File: tb/test_pm_cell.sv
module test_pm_cell;
  localparam int ROW = 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [25:0]  instr = '0;
  logic [127:0] colIn = '0, rowIn = '0, memIn = '0;
  logic [15:0]  blockWordOut, bypassOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] mRf [8];
  logic [15:0] mLut [16];
  logic [15:0] mBlk = '0, mByp = '0;

  always #5 clk = ~clk;

  pm_cell #(.ROW_IDX(ROW)) i_pm_cell (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .colLinkIn(colIn), .rowLinkIn(rowIn), .memLinkIn(memIn),
    .blockWordOut(blockWordOut), .bypassOut(bypassOut)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [25:0] mk(input logic [3:0] rows, input logic [2:0] op,
      input logic [1:0] fn, input logic [2:0] sa, input logic [2:0] sb, input logic [1:0] dst,
      input logic [2:0] s1, input logic [2:0] s2, input logic [2:0] d);
    return {rows, op, fn, sa, sb, dst, s1, s2, d};
  endfunction

  function automatic logic [15:0] pick(input logic [2:0] code, input logic [2:0] s1,
      input logic [2:0] s2);
    case (code)
      3'd0: return colIn[s1*16 +: 16];
      3'd1: return rowIn[s2*16 +: 16];
      3'd2: return memIn[s2*16 +: 16];
      3'd3: return mRf[s1];
      3'd4: return mRf[s2];
      3'd5: return mBlk;
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [25:0] w);
    if (!w[22+ROW]) return "R2";
    if (w[10:9] == 2'd3 && w[21:19] != 3'd1) return "R10";
    case (w[21:19])
      3'd0: return "R5";
      3'd1: return "R9";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      3'd7: return "R9";
      default: return "R11";
    endcase
  endfunction

  // one clock: behavioural model step, then compare away from the edge
  task automatic cycle(input logic [25:0] w, input string tag);
    logic [15:0] a, b, res;
    logic active, hasRes;
    int sh;
    instr = w;
    active = w[22+ROW];
    a = pick(w[16:14], w[8:6], w[5:3]);
    b = pick(w[13:11], w[8:6], w[5:3]);
    sh = int'(b[3:0]);
    hasRes = 1'b1;
    res = 16'h0;
    case (w[21:19])
      3'd0: res = a;
      3'd4: res = w[17] ? 16'($signed(a) >>> sh) : 16'(a >> sh);
      3'd5: case (w[18:17])
              2'd0: res = 16'(a + b);
              2'd1: res = 16'(a - b);
              2'd2: res = a & b;
              default: res = a ^ b;
            endcase
      3'd6: res = 16'((32'(a) * 32'(b)) & 32'hFFFF);
      3'd7: res = mLut[a[3:0]];
      default: hasRes = 1'b0;
    endcase
    @(posedge clk);
    if (active) begin
      if (w[21:19] == 3'd1) mLut[b[3:0]] = a;
      if (hasRes) begin
        case (w[10:9])
          2'd0: mBlk = res;
          2'd1: mByp = res;
          2'd2: mRf[w[2:0]] = res;
          default: ;
        endcase
      end
    end
    @(negedge clk);
    chk(tag, blockWordOut, mBlk);
    chk(tag, bypassOut, mByp);
  endtask

  task automatic randLinks();
    for (int k = 0; k < 4; k++) begin
      colIn[k*32 +: 32] = $urandom;
      rowIn[k*32 +: 32] = $urandom;
      memIn[k*32 +: 32] = $urandom;
    end
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mRf[i] = '0;
    for (int i = 0; i < 16; i++) mLut[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", blockWordOut, 16'h0);
    chk("R1", bypassOut, 16'h0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      colIn[k*16 +: 16] = 16'h1100 + 16'(k);
      rowIn[k*16 +: 16] = 16'h2200 + 16'(k);
      memIn[k*16 +: 16] = 16'h3300 + 16'(k);
    end
    memIn[7*16 +: 16] = 16'h8000;
    memIn[6*16 +: 16] = 16'h0004;
    // R1: storage reads back zero after reset
    cycle(mk(4'b0010, 3'd0, 2'd0, 3'd3, 3'd0, 2'd0, 3'd6, 3'd0, 3'd0), "R1");
    cycle(mk(4'b0010, 3'd7, 2'd0, 3'd0, 3'd0, 2'd1, 3'd5, 3'd0, 3'd0), "R1");
    // R4 R5: column word 2 into register 5, read back on port A and port B
    cycle(mk(4'b0010, 3'd0, 2'd0, 3'd0, 3'd0, 2'd2, 3'd2, 3'd0, 3'd5), "R5");
    cycle(mk(4'b0010, 3'd0, 2'd0, 3'd3, 3'd0, 2'd0, 3'd5, 3'd0, 3'd0), "R4");
    cycle(mk(4'b0010, 3'd0, 2'd0, 3'd4, 3'd0, 2'd1, 3'd0, 3'd5, 3'd0), "R4");
    // R4 R7: operand order in subtraction
    cycle(mk(4'b0010, 3'd5, 2'd1, 3'd5, 3'd2, 2'd1, 3'd0, 3'd3, 3'd0), "R4");
    cycle(mk(4'b0010, 3'd5, 2'd1, 3'd2, 3'd5, 2'd1, 3'd0, 3'd3, 3'd0), "R4");
    cycle(mk(4'b0010, 3'd5, 2'd0, 3'd6, 3'd7, 2'd1, 3'd0, 3'd0, 3'd0), "R4");
    // R8: product overflow
    cycle(mk(4'b0010, 3'd6, 2'd0, 3'd0, 3'd1, 2'd0, 3'd3, 3'd4, 3'd0), "R8");
    // R6: arithmetic vs logical shift of 0x8000 by 4
    cycle(mk(4'b0010, 3'd0, 2'd0, 3'd2, 3'd0, 2'd0, 3'd0, 3'd7, 3'd0), "R5");
    cycle(mk(4'b0010, 3'd4, 2'd1, 3'd5, 3'd2, 2'd1, 3'd0, 3'd6, 3'd0), "R6");
    cycle(mk(4'b0010, 3'd4, 2'd0, 3'd5, 3'd2, 2'd1, 3'd0, 3'd6, 3'd0), "R6");
    // R9: table write at index 4, then lookup through block word low nibble
    cycle(mk(4'b0010, 3'd1, 2'd0, 3'd1, 3'd2, 2'd0, 3'd0, 3'd6, 3'd0), "R9");
    cycle(mk(4'b0010, 3'd0, 2'd0, 3'd2, 3'd0, 2'd0, 3'd0, 3'd6, 3'd0), "R9");
    cycle(mk(4'b0010, 3'd7, 2'd0, 3'd5, 3'd0, 2'd1, 3'd0, 3'd0, 3'd0), "R9");
    // R2: other rows enabled, this row off
    cycle(mk(4'b1101, 3'd0, 2'd0, 3'd0, 3'd0, 2'd0, 3'd1, 3'd0, 3'd0), "R2");
    cycle(mk(4'b1101, 3'd1, 2'd0, 3'd0, 3'd2, 2'd1, 3'd1, 3'd6, 3'd0), "R2");
    cycle(mk(4'b0010, 3'd7, 2'd0, 3'd2, 3'd0, 2'd1, 3'd0, 3'd6, 3'd0), "R2");
    // R10 R11: no destination, undefined opcodes
    cycle(mk(4'b0010, 3'd0, 2'd0, 3'd0, 3'd0, 2'd3, 3'd4, 3'd0, 3'd0), "R10");
    cycle(mk(4'b0010, 3'd2, 2'd0, 3'd0, 3'd0, 2'd0, 3'd4, 3'd0, 3'd0), "R11");
    cycle(mk(4'b0010, 3'd3, 2'd0, 3'd0, 3'd0, 2'd1, 3'd4, 3'd0, 3'd0), "R11");
    // R12: outputs hold while inputs change
    randLinks();
    cycle(mk(4'b0010, 3'd2, 2'd0, 3'd0, 3'd0, 2'd0, 3'd0, 3'd0, 3'd0), "R12");
    // R3: random field mix over the whole word
    for (int n = 0; n < 4000; n++) begin
      logic [25:0] w;
      randLinks();
      w = 26'($urandom);
      cycle(w, (n % 8 == 0) ? "R3" : tagFor(w));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule